// File: doc/BRIEF.md
# Serial Two-Byte Configuration Register Port

This block is a slave serial control port. It holds sixteen 8-bit configuration registers and drives their contents to the rest of the chip as one flat bus. An external master frames each access with an active-low chip select. The master then clocks in two bytes on the serial clock. The first byte names the register and the direction of the access. The second byte carries the new value on a write, or returns the stored value on a read.

The serial pins are asynchronous to the system clock. The block samples them through a synchronizer and acts on edges of the serial clock seen in the system clock domain. The serial clock must be slow enough for the system clock to see each of its phases. The register at address 0 controls the port itself: one bit picks the shift order for both bytes, and another bit restores every register to its power-up value and then clears itself. The serial data output comes as a data bit plus an output enable. The pad ring turns these into a high-impedance pin.

Top module: `spi_regport`

## Requirements
- R1: After `rst`, register 1 holds 8'hD4 (bits 7:6 = 11, bit 5 = 0, bits 4:3 = 10, bit 2 = 1), registers 5 and 9 hold 8'h0F, and every other register holds 8'h00.
- R2: A frame whose control byte has bit 7 = 0, bits 6:4 = 000 and bits 3:0 = address writes the following data byte into that register, for addresses 0, 1, 2 and 4 to 11. The new value shows on `cfg_bank[8*addr +: 8]` after the sixteenth bit.
- R3: A control byte with bit 7 = 1 and bits 6:4 = 000 returns the addressed register on `spi_sdo` during the data byte. Each bit changes after a falling serial clock edge and is valid at the next rising edge.
- R4: `spi_sdo_oe` is 0 while `spi_cs_n` is high and 1 while it is low.
- R5: While register 0 bit 6 is 0, both bytes shift most significant bit first. While it is 1, both bytes shift least significant bit first.
- R6: Writing a data byte with bit 5 set to register 0 returns all registers to their R1 values, register 0 included, so that register's bits 5 and 6 read back as 0.
- R7: A control byte with any of bits 6:4 set changes no register, and a read framed this way returns 0.
- R8: Writes to address 3 or to addresses 12 to 15 change nothing, and reads from these addresses return 0.
- R9: A frame cut short by `spi_cs_n` rising before the sixteenth bit leaves every register unchanged.
- R10: Serial clock edges while `spi_cs_n` is high are ignored. Bits after the sixteenth in a frame are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock from master, idles low |
| spi_cs_n | input | 1 | Active-low frame select |
| spi_sdi | input | 1 | Serial data in, sampled on rising serial clock |
| spi_sdo | output | 1 | Serial data out, meaningful when enabled |
| spi_sdo_oe | output | 1 | Output enable for the serial data pad |
| cfg_bank | output | 128 | All registers, register n at bits 8n+7:8n |

## Verification
Every address is written and then read back in both shift orders. Each address gets a different data value in each order, so a decode fault or a swap of shift order shows up as a value on the wrong register or a reflected byte. Malformed control bytes, frames cut short at twelve bits, frames padded to twenty bits, and serial clock activity with the select high are each followed by a bank comparison. These separate the legal frame from framing faults. A soft reset issued while in least-significant-first mode checks that the shift order returns to its default together with the rest of the bank.

// File: rtl/spi_regport_pkg.sv
package spi_regport_pkg;
  localparam int REG_W     = 8;
  localparam int ADDR_W    = 4;
  localparam int NUM_REGS  = 1 << ADDR_W;
  localparam int RW_BIT    = 7;
  localparam int LSB_BIT   = 6;
  localparam int SRST_BIT  = 5;

  function automatic logic [REG_W-1:0] reg_default(input int idx);
    case (idx)
      1:       return 8'hD4;
      5, 9:    return 8'h0F;
      default: return '0;
    endcase
  endfunction

  function automatic logic [NUM_REGS*REG_W-1:0] bank_default();
    logic [NUM_REGS*REG_W-1:0] v;
    for (int i = 0; i < NUM_REGS; i++) v[i*REG_W +: REG_W] = reg_default(i);
    return v;
  endfunction
endpackage

// File: rtl/spi_regport_sync.sv
module spi_regport_sync #(
  parameter int              W       = 3,
  parameter int              STAGES  = 2,
  parameter logic [W-1:0]    RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [STAGES-1:0][W-1:0] chain;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= RST_VAL;
    end else begin
      chain[0] <= din;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign dout = chain[STAGES-1];
endmodule

// File: rtl/spi_regport_frame.sv
module spi_regport_frame
  import spi_regport_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              sclk_s,
  input  logic              cs_n_s,
  input  logic              sdi_s,
  input  logic              lsb_first,
  input  logic [REG_W-1:0]  rd_data,
  output logic [ADDR_W-1:0] rd_addr,
  output logic              wr_stb,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [REG_W-1:0]  wr_data,
  output logic              sdo_q,
  output logic              sdo_oe
);
  localparam int FRAME_BITS = 2 * REG_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 1);
  localparam int IDX_W      = $clog2(REG_W);
  localparam logic [CNT_W-1:0] BYTE_LAST  = CNT_W'(REG_W - 1);
  localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_BITS - 1);
  localparam logic [CNT_W-1:0] FRAME_END  = CNT_W'(FRAME_BITS);
  localparam logic [CNT_W-1:0] DATA_FIRST = CNT_W'(REG_W);

  logic             sclk_d;
  logic [CNT_W-1:0] cnt;
  logic [REG_W-1:0] sh, nxt, ctrl;
  logic             rise, fall, ctrl_ok, is_rd, in_data, out_bit;
  logic [IDX_W-1:0] k_idx;

  assign rise    = sclk_s & ~sclk_d;
  assign fall    = ~sclk_s & sclk_d;
  assign nxt     = lsb_first ? {sdi_s, sh[REG_W-1:1]} : {sh[REG_W-2:0], sdi_s};
  assign ctrl_ok = (ctrl[RW_BIT-1:ADDR_W] == '0);
  assign is_rd   = ctrl_ok & ctrl[RW_BIT];
  assign in_data = (cnt >= DATA_FIRST) && (cnt < FRAME_END);
  assign k_idx   = IDX_W'(cnt - DATA_FIRST);
  assign out_bit = lsb_first ? rd_data[k_idx] : rd_data[REG_W-1-int'(k_idx)];
  assign rd_addr = ctrl[ADDR_W-1:0];

  always_ff @(posedge clk) begin
    wr_stb <= 1'b0;
    if (rst) begin
      sclk_d  <= 1'b0;
      cnt     <= '0;
      sh      <= '0;
      ctrl    <= '0;
      wr_addr <= '0;
      wr_data <= '0;
      sdo_q   <= 1'b0;
      sdo_oe  <= 1'b0;
    end else begin
      sclk_d <= sclk_s;
      sdo_oe <= ~cs_n_s;
      if (cs_n_s) begin
        cnt   <= '0;
        sdo_q <= 1'b0;
      end else if (rise && cnt < FRAME_END) begin
        sh  <= nxt;
        cnt <= cnt + 1'b1;
        if (cnt == BYTE_LAST) ctrl <= nxt;
        if (cnt == FRAME_LAST) begin
          wr_stb  <= ctrl_ok & ~ctrl[RW_BIT];
          wr_addr <= ctrl[ADDR_W-1:0];
          wr_data <= nxt;
        end
      end else if (fall && in_data && is_rd) begin
        sdo_q <= out_bit;
      end
    end
  end

  p_cnt_bound_r10: assert property (@(posedge clk) disable iff (rst)
    cnt <= FRAME_END);
  p_no_commit_idle_r9: assert property (@(posedge clk) disable iff (rst)
    cs_n_s |=> !wr_stb);
  p_sdo_hold_rise_r3: assert property (@(posedge clk) disable iff (rst)
    (rise && !cs_n_s) |=> $stable(sdo_q));
endmodule

// File: rtl/spi_regport_regs.sv
module spi_regport_regs
  import spi_regport_pkg::*;
#(
  parameter int LAST_ADDR = 11,
  parameter int HOLE_ADDR = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      wr_stb,
  input  logic [ADDR_W-1:0]         wr_addr,
  input  logic [REG_W-1:0]          wr_data,
  input  logic [ADDR_W-1:0]         rd_addr,
  output logic [REG_W-1:0]          rd_data,
  output logic                      lsb_first,
  output logic [NUM_REGS*REG_W-1:0] bank
);
  localparam logic [NUM_REGS*REG_W-1:0] BANK_DEF = bank_default();

  function automatic logic addr_ok(input logic [ADDR_W-1:0] a);
    return (int'(a) <= LAST_ADDR) && (int'(a) != HOLE_ADDR);
  endfunction

  logic [REG_W-1:0] regs [NUM_REGS];
  logic             srst;

  assign srst = wr_stb && (wr_addr == '0) && wr_data[SRST_BIT];

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    if (i <= LAST_ADDR && i != HOLE_ADDR) begin : g_rw
      always_ff @(posedge clk) begin
        if (rst || srst)
          regs[i] <= reg_default(i);
        else if (wr_stb && wr_addr == ADDR_W'(i))
          regs[i] <= wr_data;
      end
    end else begin : g_fixed
      assign regs[i] = reg_default(i);
    end
    assign bank[i*REG_W +: REG_W] = regs[i];
  end

  assign rd_data   = addr_ok(rd_addr) ? regs[rd_addr] : '0;
  assign lsb_first = regs[0][LSB_BIT];

  p_hole_ignored_r8: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && !addr_ok(wr_addr)) |=> $stable(bank));
  p_soft_reset_r6: assert property (@(posedge clk) disable iff (rst)
    srst |=> (bank == BANK_DEF));
  p_write_lands_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_stb && addr_ok(wr_addr) && !srst) |=>
      (bank[$past(wr_addr)*REG_W +: REG_W] == $past(wr_data)));
endmodule

// File: rtl/spi_regport.sv
module spi_regport
  import spi_regport_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int LAST_ADDR   = 11,
  parameter int HOLE_ADDR   = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic                      spi_sclk,
  input  logic                      spi_cs_n,
  input  logic                      spi_sdi,
  output logic                      spi_sdo,
  output logic                      spi_sdo_oe,
  output logic [NUM_REGS*REG_W-1:0] cfg_bank
);
  logic              sclk_s, cs_n_s, sdi_s, lsb_first, wr_stb;
  logic [ADDR_W-1:0] rd_addr, wr_addr;
  logic [REG_W-1:0]  rd_data, wr_data;

  spi_regport_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b010)) u_sync (
    .clk  (clk),
    .rst  (rst),
    .din  ({spi_sclk, spi_cs_n, spi_sdi}),
    .dout ({sclk_s, cs_n_s, sdi_s})
  );

  spi_regport_frame u_frame (
    .clk       (clk),
    .rst       (rst),
    .sclk_s    (sclk_s),
    .cs_n_s    (cs_n_s),
    .sdi_s     (sdi_s),
    .lsb_first (lsb_first),
    .rd_data   (rd_data),
    .rd_addr   (rd_addr),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .sdo_q     (spi_sdo),
    .sdo_oe    (spi_sdo_oe)
  );

  spi_regport_regs #(.LAST_ADDR(LAST_ADDR), .HOLE_ADDR(HOLE_ADDR)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .wr_stb    (wr_stb),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .rd_addr   (rd_addr),
    .rd_data   (rd_data),
    .lsb_first (lsb_first),
    .bank      (cfg_bank)
  );

  p_oe_quiet_r4: assert property (@(posedge clk) disable iff (rst)
    !spi_sdo_oe |-> !spi_sdo);
endmodule

// File: tb/spi_regport_bench.sv
module spi_regport_bench;
  localparam int HALF = 6;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sclk = 1'b0, cs_n = 1'b1, sdi = 1'b0;
  logic         sdo, sdo_oe;
  logic [127:0] bank;
  logic [7:0]   expv [16];
  int           n_chk = 0, n_bad = 0;
  bit           done = 0;

  always #10 clk = ~clk;

  spi_regport u_spi_regport (
    .clk(clk), .rst(rst), .spi_sclk(sclk), .spi_cs_n(cs_n), .spi_sdi(sdi),
    .spi_sdo(sdo), .spi_sdo_oe(sdo_oe), .cfg_bank(bank)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp_v);
    n_chk++;
    if (act !== exp_v) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp_v);
    end
  endtask

  function automatic bit wr_ok(input int a);
    return a <= 11 && a != 3;
  endfunction

  task automatic model_defaults();
    for (int i = 0; i < 16; i++) expv[i] = 8'h00;
    expv[1] = 8'hD4; expv[5] = 8'h0F; expv[9] = 8'h0F;
  endtask

  task automatic check_bank(input string tag);
    for (int i = 0; i < 16; i++) chk(tag, 32'(bank[i*8 +: 8]), 32'(expv[i]));
  endtask

  task automatic xfer(input logic [7:0] ctrl, input logic [7:0] dat,
                      input int nbits, output logic [7:0] rd);
    bit lsb;
    lsb = expv[0][6];
    rd = 8'h00;
    @(negedge clk) cs_n = 1'b0;
    repeat (HALF) @(negedge clk);
    chk("R4 oe while selected", 32'(sdo_oe), 32'd1);
    for (int i = 0; i < nbits; i++) begin
      logic [7:0] b;
      int k;
      b = (i < 8) ? ctrl : dat;
      k = i % 8;
      sdi = (i >= 16) ? 1'b1 : (lsb ? b[k] : b[7-k]);
      repeat (HALF) @(negedge clk);
      if (i >= 8 && i < 16) begin
        if (lsb) rd[k] = sdo; else rd[7-k] = sdo;
      end
      sclk = 1'b1;
      repeat (HALF) @(negedge clk);
      sclk = 1'b0;
    end
    repeat (HALF) @(negedge clk);
    cs_n = 1'b1;
    repeat (3 * HALF) @(negedge clk);
    chk("R4 oe while idle", 32'(sdo_oe), 32'd0);
  endtask

  task automatic do_write(input int a, input logic [7:0] d);
    logic [7:0] rd;
    xfer({4'h0, 4'(a)}, d, 16, rd);
    if (a == 0 && d[5]) model_defaults();
    else if (wr_ok(a)) expv[a] = d;
  endtask

  task automatic do_read(input string tag, input int a);
    logic [7:0] rd;
    xfer({4'h8, 4'(a)}, 8'h00, 16, rd);
    chk(tag, 32'(rd), 32'(wr_ok(a) ? expv[a] : 8'h00));
  endtask

  initial begin
    repeat (2000000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd, d;
    model_defaults();
    repeat (5) @(negedge clk);
    rst = 1'b0;
    repeat (5) @(negedge clk);
    check_bank("R1 reset defaults");
    chk("R4 oe after reset", 32'(sdo_oe), 32'd0);

    // R2 R3 R8: MSB-first sweep of every address
    for (int a = 0; a < 16; a++) begin
      d = 8'(a * 29 + 8'h5B);
      if (a == 0) d = d & 8'h9F;
      do_write(a, d);
      check_bank("R2 R8 write msb");
    end
    for (int a = 0; a < 16; a++) do_read("R3 R8 read msb", a);

    // R5: switch to LSB-first, then sweep again
    do_write(0, 8'h40);
    check_bank("R5 order bit set");
    for (int a = 0; a < 16; a++) begin
      d = 8'(a * 53 + 8'hA6);
      if (a == 0) d = (d & 8'h9F) | 8'h40;
      do_write(a, d);
      check_bank("R5 write lsb");
    end
    for (int a = 0; a < 16; a++) do_read("R5 read lsb", a);

    // R7: malformed control bytes
    xfer(8'h12, 8'hAA, 16, rd);
    check_bank("R7 bad ctrl write");
    xfer(8'hA1, 8'h00, 16, rd);
    chk("R7 bad ctrl read", 32'(rd), 32'd0);

    // R9: frame aborted after 12 bits
    xfer(8'h04, 8'h3C, 12, rd);
    check_bank("R9 aborted frame");

    // R10: extra bits past sixteen, and clocks while deselected
    do_write(6, 8'h77);
    xfer(8'h06, 8'h99, 20, rd);
    expv[6] = 8'h99;
    check_bank("R10 trailing bits");
    sdi = 1'b1;
    for (int i = 0; i < 16; i++) begin
      repeat (HALF) @(negedge clk); sclk = 1'b1;
      repeat (HALF) @(negedge clk); sclk = 1'b0;
    end
    check_bank("R10 clocks while idle");
    do_read("R10 frame after idle clocks", 1);

    // R6: soft reset issued in LSB-first mode
    do_write(0, 8'h60);
    check_bank("R6 soft reset");
    do_read("R6 reg0 after soft reset", 0);
    do_read("R6 reg5 after soft reset", 5);

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule